// File: doc/BRIEF.md
# Latched Alert and Comparator Pin Driver

This block drives a single active-low alert pin from a vector of status flags, such as fault, warning and over-threshold results. A per-bit enable mask decides which flags may raise the pin. In latched mode, every incoming flag is captured into a sticky status register. The pin goes low only when an enabled flag rises into a status bit that was not already set. Changing the mask or repeating an old event therefore never raises the pin again.

The host finds and services the alert in two ways. When the bus responder reports that this device has delivered its address in an alert-response read, the pin is released, and the captured status stays intact for a later read. A clear command empties the whole status register and also releases the pin. After a release, any further fresh enabled flag pulls the pin low again. If a flag arrives in the same cycle as a clear, the flag wins: it is latched into the emptied register and may raise the pin.

In comparator mode the pin does not latch. It follows one selected live flag, delayed by one register stage, much like a digital threshold comparator. The status register keeps capturing flags in this mode, and the latched alert state keeps being tracked. When the block returns to latched mode, the pin shows whatever has been collected in the meantime. All inputs are plain control and status levels or one-cycle strobes. No stream interface is involved, so there is no back-pressure.

Top module: `alert_pin_driver`

## Requirements
- R1: During and right after reset, `alert_n_o` is 1 and `status_o` is all zeros.
- R2: A bit of `status_o` becomes 1 on the clock after the matching `evt_i` bit is 1. It stays 1 until a clear, whatever `evt_i` does afterwards.
- R3: In latched mode (`mode_i` = 0), `alert_n_o` goes to 0 one clock after an `evt_i` bit is 1 while its `en_i` bit is 1 and its status bit is 0.
- R4: An event on a bit whose `en_i` is 0 sets its status bit but does not pull `alert_n_o` low.
- R5: An event on a status bit that is already 1 does not pull the pin low. Setting `en_i` for a bit that is already latched does not pull the pin low either.
- R6: A one-cycle `ara_win_i` pulse drives `alert_n_o` to 1 on the next clock and leaves `status_o` unchanged, as long as no fresh enabled event arrives in the same cycle.
- R7: A one-cycle `clr_i` pulse with no event in the same cycle sets `status_o` to zero and `alert_n_o` to 1 on the next clock.
- R8: An event arriving in the same cycle as `clr_i` wins. On the next clock, `status_o` equals that cycle's `evt_i`, and the pin is low if any of those bits is enabled.
- R9: A fresh enabled event re-asserts the pin after an `ara_win_i` release. A fresh enabled event also beats an `ara_win_i` pulse in the same cycle, so the pin stays low.
- R10: In comparator mode (`mode_i` = 1), `alert_n_o` is the inverse of `evt_i[cmp_sel_i]` as sampled on the previous clock. Neither the mask nor the latched state has any effect.
- R11: Latching and alert tracking continue during comparator mode. After a return to `mode_i` = 0, the pin shows the alert state built up in the meantime, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NBITS | Live status flags, 1 = condition present |
| en_i | input | NBITS | Per-bit alert enable mask |
| mode_i | input | 1 | 0 = latched alert, 1 = comparator follow |
| cmp_sel_i | input | SEL_W | Index of the flag followed in comparator mode |
| clr_i | input | 1 | Clear command strobe: empties status, releases pin |
| ara_win_i | input | 1 | Strobe: address delivered in alert-response read |
| status_o | output | NBITS | Latched sticky status bits |
| alert_n_o | output | 1 | Active-low alert pin |

## Verification
The bench targets four corner cases:
- **Clear and event in the same cycle.** A design that gave the clear priority would drop a fault that arrived exactly then, and the pin would stay high.
- **Address-delivery release.** A design that cleared status on that release would lose the captured flags. A design that ignored a fresh event in the same cycle would release a pin that must stay low.
- **Repeated events and late mask changes.** A design that detected edges on the raw input, or on the mask, instead of against the latched bit would raise spurious alerts.
- **Mode switches.** A design that froze latching in comparator mode would come back to latched mode with a stale pin.

// File: rtl/alert_pkg.sv
package alert_pkg;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_CMP   = 1'b1
  } pin_mode_e;

endpackage

// File: rtl/alert_bit_cell.sv
module alert_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic sticky_o,
  output logic fresh_o
);

  logic sticky_q;
  logic base_w;

  // A clear empties the bit first, so an event in the clear cycle is seen as fresh.
  assign base_w   = clr_i ? 1'b0 : sticky_q;
  assign fresh_o  = evt_i & en_i & ~base_w;
  assign sticky_o = sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= base_w | evt_i;
  end

  // R2: a latched bit only falls through a clear
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr_i) |=> sticky_q);

  // R2: an event always lands in the bit
  p_event_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> sticky_q);

endmodule

// File: rtl/alert_latch_ctl.sv
module alert_latch_ctl #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] fresh_i,
  input  logic             clr_i,
  input  logic             ara_win_i,
  output logic             alert_o
);

  logic alert_q;
  logic any_fresh_w;

  assign any_fresh_w = |fresh_i;
  assign alert_o     = alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  alert_q <= 1'b0;
    else if (any_fresh_w)        alert_q <= 1'b1;
    else if (clr_i || ara_win_i) alert_q <= 1'b0;
  end

  // R3, R9: a fresh enabled event always raises the alert
  p_fresh_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fresh_i) |=> alert_q);

  // R6: release on address delivery without a new event
  p_ara_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_win_i && fresh_i == '0) |=> !alert_q);

  // R5: no alert appears without a fresh event
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_q && fresh_i == '0) |=> !alert_q);

endmodule

// File: rtl/alert_cmp_follow.sv
module alert_cmp_follow #(
  parameter int NBITS = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             above_o
);

  logic above_q;
  logic pick_w;

  always_comb begin
    pick_w = 1'b0;
    for (int i = 0; i < NBITS; i++) begin
      if (sel_i == SEL_W'(i)) pick_w = evt_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= pick_w;
  end

  assign above_o = above_q;

endmodule

// File: rtl/alert_pin_driver.sv
module alert_pin_driver #(
  parameter int NBITS = 16,
  localparam int SEL_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt_i,
  input  logic [NBITS-1:0] en_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] cmp_sel_i,
  input  logic             clr_i,
  input  logic             ara_win_i,
  output logic [NBITS-1:0] status_o,
  output logic             alert_n_o
);

  import alert_pkg::*;

  logic [NBITS-1:0] sticky_w;
  logic [NBITS-1:0] fresh_w;
  logic             alert_w;
  logic             above_w;
  pin_mode_e        mode_w;
  logic             live_q;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    alert_bit_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[b]),
      .en_i     (en_i[b]),
      .clr_i    (clr_i),
      .sticky_o (sticky_w[b]),
      .fresh_o  (fresh_w[b])
    );
  end

  alert_latch_ctl #(.NBITS(NBITS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fresh_i   (fresh_w),
    .clr_i     (clr_i),
    .ara_win_i (ara_win_i),
    .alert_o   (alert_w)
  );

  alert_cmp_follow #(.NBITS(NBITS), .SEL_W(SEL_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .sel_i   (cmp_sel_i),
    .above_o (above_w)
  );

  assign mode_w    = pin_mode_e'(mode_i);
  assign status_o  = sticky_w;
  assign alert_n_o = (mode_w == MODE_CMP) ? ~above_w : ~alert_w;

  // Marks that at least one clock has passed since reset, so history checks are valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R7: a clear with no event empties the status
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (status_o == '0));

  // R8: an event in the clear cycle is what remains latched
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (status_o == $past(evt_i)));

  // R10: comparator mode follows the selected flag, one cycle late
  p_cmp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && mode_i && $past(mode_i)) |-> (alert_n_o == !$past(evt_i[cmp_sel_i])));

  // R6: address delivery never disturbs status
  p_ara_keeps_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_win_i && !clr_i && evt_i == '0) |=> $stable(status_o));

endmodule

// File: tb/tb_alert_pin_driver.sv
`timescale 1ns/1ps
module tb_alert_pin_driver;

  localparam int NB = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] evt = '0;
  logic [NB-1:0] en = '0;
  logic          mode = 1'b0;
  logic [SW-1:0] sel = '0;
  logic          clr = 1'b0;
  logic          ara = 1'b0;
  logic [NB-1:0] status;
  logic          alert_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  logic [NB-1:0] m_st = '0;
  logic          m_alert = 1'b0;
  logic          m_cmp = 1'b0;

  always #2.5 clk = ~clk;

  alert_pin_driver #(.NBITS(NB)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .en_i      (en),
    .mode_i    (mode),
    .cmp_sel_i (sel),
    .clr_i     (clr),
    .ara_win_i (ara),
    .status_o  (status),
    .alert_n_o (alert_n)
  );

  function automatic logic [NB-1:0] next_status(logic [NB-1:0] st, logic [NB-1:0] e, logic c);
    return (c ? '0 : st) | e;
  endfunction

  function automatic logic next_alert(logic a, logic [NB-1:0] st, logic [NB-1:0] e,
                                      logic [NB-1:0] m, logic c, logic r);
    logic [NB-1:0] base;
    base = c ? '0 : st;
    if ((e & m & ~base) != '0) return 1'b1;
    if (c || r) return 1'b0;
    return a;
  endfunction

  function automatic logic exp_pin(logic md, logic a, logic cq);
    return md ? ~cq : ~a;
  endfunction

  task automatic check_out(string tag);
    logic ep;
    ep = exp_pin(mode, m_alert, m_cmp);
    n_checks++;
    if (status !== m_st) begin
      n_fail++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, m_st);
    end
    n_checks++;
    if (alert_n !== ep) begin
      n_fail++;
      $display("FAIL %s alert_n actual=%b expected=%b", tag, alert_n, ep);
    end
  endtask

  task automatic step(logic [NB-1:0] e, logic [NB-1:0] m, logic md, logic [SW-1:0] s,
                      logic c, logic r, string tag);
    @(negedge clk);
    evt = e; en = m; mode = md; sel = s; clr = c; ara = r;
    m_alert = next_alert(m_alert, m_st, e, m, c, r);
    m_st    = next_status(m_st, e, c);
    m_cmp   = e[s];
    @(posedge clk);
    #1;
    check_out(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_out("R1 after reset");

    step(16'h0001, 16'h0001, 0, 0, 0, 0, "R3 enabled rise");
    step(16'h0000, 16'h0001, 0, 0, 0, 0, "R2 sticky hold");
    step(16'h0000, 16'h0001, 0, 0, 1, 0, "R7 clear");
    step(16'h0004, 16'h0001, 0, 0, 0, 0, "R4 disabled event");
    step(16'h0000, 16'h0004, 0, 0, 0, 0, "R5 late mask");
    step(16'h0004, 16'h0004, 0, 0, 0, 0, "R5 repeat event");
    step(16'h0010, 16'h0010, 0, 0, 0, 0, "R3 second rise");
    step(16'h0000, 16'h0010, 0, 0, 0, 1, "R6 ara release");
    step(16'h0010, 16'h0010, 0, 0, 0, 0, "R5 repeat while silenced");
    step(16'h0020, 16'h0020, 0, 0, 0, 0, "R9 reassert");
    step(16'h0040, 16'h0040, 0, 0, 0, 1, "R9 event beats ara");
    step(16'h0008, 16'h0008, 0, 0, 1, 0, "R8 event wins clear");
    step(16'h0008, 16'h0000, 0, 0, 1, 0, "R8 disabled with clear");
    step(16'h0008, 16'h0000, 1, 3, 0, 0, "R10 cmp above");
    step(16'h0000, 16'h0000, 1, 3, 0, 0, "R10 cmp below");
    step(16'h0100, 16'h0100, 1, 3, 0, 0, "R11 latch in cmp mode");
    step(16'h0000, 16'h0000, 0, 3, 0, 0, "R11 back to latched");

    for (int i = 0; i < 3000; i++) begin
      logic [NB-1:0] e;
      logic [NB-1:0] m;
      logic md;
      logic c;
      logic r;
      e  = ($urandom % 4 == 0) ? NB'($urandom) & NB'($urandom) & NB'($urandom) : '0;
      m  = NB'($urandom);
      md = ($urandom % 8 == 0);
      c  = ($urandom % 12 == 0);
      r  = ($urandom % 6 == 0);
      step(e, m, md, SW'($urandom), c, r, md ? "R10 random" : "R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1279));
  end

endmodule